// File: doc/BRIEF.md
# Clause-22 PHY Management Master

This block runs the two-wire management link to an Ethernet PHY. Software programs a command word and a 16-bit data word. The command word holds the PHY address, the register number, a clock-range code, a direction bit and a go/busy bit. Setting the busy bit while the block is idle launches one clause-22 frame. The block derives the management clock from the system clock with a divisor picked by the range code. It shifts the frame out MSB first and controls the tristate enable of the data line.

A write frame carries the data word to the PHY. For a read frame, the block releases the data line from the turnaround onward and samples the PHY's reply on rising management-clock edges. The result lands in the data word. The busy bit reads 1 until the frame ends, and command or data writes made during that time are discarded. The data pin is presented as separate input, output and output-enable signals so that the pad can sit outside the block.

Top module: `mdio_master`

## Requirements
- R1: The command readback places the PHY address in bits [15:11], the register number in bits [10:6], a constant 0 in bit 5, the clock-range code in bits [4:2], the direction in bit 1 (1 = write, 0 = read) and busy in bit 0.
- R2: When idle, a command write with bit 0 = 1 starts a frame, and busy reads 1 from the next cycle. A command write with bit 0 = 0 only updates the fields and leaves the management clock low.
- R3: The clock-range code selects the divisor: 000 gives 42, 010 gives 16, 011 gives 26, and every other code gives 42. The management clock period equals the divisor in system clocks.
- R4: The management clock is high for half the divisor and low for the other half. It idles low, and each frame starts with a low half period.
- R5: A write frame, read at rising management-clock edges, is 32 ones, start 01, opcode 01, the 5-bit address, the 5-bit register number, turnaround 10, then the 16 data bits, MSB first. The enable is high for all 64 bits.
- R6: A read frame uses opcode 10. The enable is low from the first turnaround bit (bit 46) through the last data bit. The input is sampled at the 16 rising edges of the data phase, MSB first.
- R7: Busy stays high for exactly 64 x divisor cycles and clears on the edge that ends the last bit. On a read, the data word holds the sampled value from that same edge.
- R8: Command writes made while busy is 1 change no field and start nothing.
- R9: Data writes made while busy is 1 are discarded.
- R10: After reset, both readbacks are 0, the management clock is low and the enable is low.
- R11: The output data bit changes only on falling management-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word write value |
| data_wr | input | 1 | Data word write strobe |
| data_wdata | input | 16 | Data word write value |
| cmd_rdata | output | 16 | Command word readback, busy in bit 0 |
| data_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
The bench builds the block with its default parameters: divisors 42, 16 and 26, a 32-bit preamble and 16 data bits. With these values, all three listed range codes and two unlisted fall-back codes can be reached, and full-length frames are compared bit for bit. Frames of 1024 to 2688 system cycles keep the exact busy-length and half-period measurements affordable. A bench-side PHY answers reads with patterns whose set bits sit at both ends of the word, which exposes any reversed or shifted sampling.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] SOF_BITS  = 2'b01;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] TA_DRIVE  = 2'b10;
  localparam logic [2:0] CR_MID    = 3'b010;
  localparam logic [2:0] CR_HIGH   = 3'b011;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIVW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            mdc,
  output logic            rise_tick,
  output logic            fall_tick
);
  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] half;

  assign half      = div >> 1;
  assign rise_tick = run && (cnt_q == half - DIVW'(1));
  assign fall_tick = run && (cnt_q == div - DIVW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= fall_tick ? '0 : cnt_q + DIVW'(1);
      if (rise_tick)      mdc <= 1'b1;
      else if (fall_tick) mdc <= 1'b0;
    end
  end

  // R4: clock parks low once the sequencer stops
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
  // R4: clock rises exactly mid-period
  a_r4_rise_mid: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> cnt_q == half);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_wr,
  input  logic [AW-1:0] start_phy,
  input  logic [AW-1:0] start_reg,
  input  logic [DW-1:0] start_data,
  input  logic          rise_tick,
  input  logic          fall_tick,
  input  logic          mdio_i,
  output logic          run,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          rd_valid,
  output logic [DW-1:0] rd_word
);
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * AW + DW;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * AW;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int BCW       = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] frame_w;
  logic [BCW-1:0]       bit_q;
  logic [BCW-1:0]       bit_nx;
  logic                 wr_q;
  logic [DW-1:0]        rsh_q;
  logic                 last_bit;

  assign frame_w  = {{PRE_LEN{1'b1}}, SOF_BITS, (start_wr ? OP_WRITE : OP_READ),
                     start_phy, start_reg, TA_DRIVE, start_data};
  assign bit_nx   = bit_q + BCW'(1);
  assign last_bit = (bit_q == BCW'(FRAME_LEN - 1));
  assign rd_valid = run && fall_tick && last_bit && !wr_q;
  assign rd_word  = rsh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      wr_q    <= 1'b0;
      rsh_q   <= '0;
    end else begin
      if (start && !run) begin
        run     <= 1'b1;
        wr_q    <= start_wr;
        sh_q    <= frame_w << 1;
        mdio_o  <= frame_w[FRAME_LEN-1];
        mdio_oe <= 1'b1;
        bit_q   <= '0;
      end else if (run && fall_tick) begin
        if (last_bit) begin
          run     <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          bit_q   <= bit_nx;
          mdio_o  <= sh_q[FRAME_LEN-1];
          sh_q    <= sh_q << 1;
          mdio_oe <= wr_q || (bit_nx < BCW'(TA_POS));
        end
      end
      if (run && rise_tick && !wr_q && (bit_q >= BCW'(DATA_POS)))
        rsh_q <= {rsh_q[DW-2:0], mdio_i};
    end
  end

  // R11: data bit only moves on a falling clock edge
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !fall_tick) |=> $stable(mdio_o));
  // R6: line released through turnaround and data phase of a read
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (run && !wr_q && (bit_q >= BCW'(TA_POS))) |-> !mdio_oe);
  // R7: frame ends only on a period boundary
  a_r7_end_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(fall_tick));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_CODE0 = 42,
  parameter int DIV_CODE2 = 16,
  parameter int DIV_CODE3 = 26,
  parameter int PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_wdata,
  input  logic        data_wr,
  input  logic [15:0] data_wdata,
  output logic [15:0] cmd_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int AW      = 5;
  localparam int DW      = 16;
  localparam int DIV_M1  = (DIV_CODE0 > DIV_CODE2) ? DIV_CODE0 : DIV_CODE2;
  localparam int DIV_MAX = (DIV_M1 > DIV_CODE3) ? DIV_M1 : DIV_CODE3;
  localparam int DIVW    = $clog2(DIV_MAX + 1);

  logic [AW-1:0]   phy_q, reg_q;
  logic [2:0]      cr_q;
  logic            wr_q;
  logic [DW-1:0]   data_q;
  logic [DIVW-1:0] div_q, div_sel;
  logic            busy, start;
  logic            rise_tick, fall_tick;
  logic            rd_valid;
  logic [DW-1:0]   rd_word;

  assign start = cmd_wr && !busy && cmd_wdata[0];

  always_comb begin
    case (cmd_wdata[4:2])
      CR_MID:  div_sel = DIVW'(DIV_CODE2);
      CR_HIGH: div_sel = DIVW'(DIV_CODE3);
      default: div_sel = DIVW'(DIV_CODE0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_q  <= '0;
      reg_q  <= '0;
      cr_q   <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
      div_q  <= DIVW'(DIV_CODE0);
    end else begin
      if (cmd_wr && !busy) begin
        phy_q <= cmd_wdata[15:11];
        reg_q <= cmd_wdata[10:6];
        cr_q  <= cmd_wdata[4:2];
        wr_q  <= cmd_wdata[1];
      end
      if (start) div_q <= div_sel;
      if (rd_valid)               data_q <= rd_word;
      else if (data_wr && !busy)  data_q <= data_wdata;
    end
  end

  assign cmd_rdata  = {phy_q, reg_q, 1'b0, cr_q, wr_q, busy};
  assign data_rdata = data_q;

  mdio_clkdiv #(.DIVW(DIVW)) clkdiv_i (
    .clk(clk), .rst(rst), .run(busy), .div(div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .start_wr(cmd_wdata[1]), .start_phy(cmd_wdata[15:11]),
    .start_reg(cmd_wdata[10:6]), .start_data(data_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .run(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_valid(rd_valid), .rd_word(rd_word)
  );

  // R8: command fields frozen while a frame runs
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable({phy_q, reg_q, cr_q, wr_q}));
  // R9: data word frozen against software while a frame runs
  a_r9_data_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && data_wr && !rd_valid) |=> $stable(data_q));
  // R2: a frame start always raises busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [15:0] cmd_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] rg;
    logic [2:0] cr;
    logic [15:0] val;
    logic [7:0] ndiv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 5'h01, 5'h00, 3'b000, 16'hA5C3, 8'd42},
    '{1'b0, 5'h1F, 5'h1F, 3'b010, 16'h8001, 8'd16},
    '{1'b1, 5'h10, 5'h0A, 3'b011, 16'h0000, 8'd26},
    '{1'b0, 5'h00, 5'h01, 3'b101, 16'h7FFE, 8'd42},
    '{1'b0, 5'h15, 5'h0E, 3'b111, 16'h1234, 8'd42},
    '{1'b1, 5'h0A, 5'h15, 3'b010, 16'hFFFF, 8'd16}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_frame(input vec_t v);
    logic [63:0] ef, cap_o, cap_oe;
    logic [15:0] exp_cmd;
    time t_s, t_r0, t_f0, t_r1, t_end;
    int cyc;
    ef = {32'hFFFF_FFFF, 2'b01, (v.wr ? 2'b01 : 2'b10), v.phy, v.rg, 2'b10, v.val};
    @(negedge clk);
    data_wr = 1'b1; data_wdata = v.wr ? v.val : 16'h5A5A;
    @(negedge clk);
    data_wr = 1'b0;
    cmd_wr = 1'b1; cmd_wdata = {v.phy, v.rg, 1'b0, v.cr, v.wr, 1'b1};
    t_s = $time;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata[0] == 1'b1, "R2 busy after start", 64'(cmd_rdata[0]), 64'd1);
    t_r0 = 0; t_f0 = 0; t_r1 = 0;
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      if (k == 0) t_r0 = $time;
      if (k == 1) t_r1 = $time;
      cap_o[63-k]  = mdio_o;
      cap_oe[63-k] = mdio_oe;
      @(negedge mdc);
      if (k == 0) t_f0 = $time;
      if (k + 1 >= 48 && k + 1 < 64) mdio_i = v.val[63-(k+1)];
      else if (k + 1 == 47) mdio_i = 1'b0;
      else mdio_i = 1'b1;
    end
    mdio_i = 1'b1;
    @(negedge clk);
    while (cmd_rdata[0]) @(negedge clk);
    t_end = $time;
    cyc = int'((t_end - t_s) / 4);
    check(((t_r1 - t_r0) / 4) == 64'(v.ndiv), "R3 mdc period", 64'((t_r1 - t_r0) / 4), 64'(v.ndiv));
    check(((t_f0 - t_r0) / 4) == 64'(v.ndiv / 2), "R4 mdc high time", 64'((t_f0 - t_r0) / 4), 64'(v.ndiv / 2));
    check(((t_r0 - t_s - 2) / 4) == 64'(v.ndiv / 2), "R4 first low half", 64'((t_r0 - t_s - 2) / 4), 64'(v.ndiv / 2));
    check(cyc == 64 * int'(v.ndiv) + 1, "R7 busy length", 64'(cyc), 64'(64 * int'(v.ndiv) + 1));
    exp_cmd = {v.phy, v.rg, 1'b0, v.cr, v.wr, 1'b0};
    check(cmd_rdata == exp_cmd, "R1 command readback", 64'(cmd_rdata), 64'(exp_cmd));
    if (v.wr) begin
      check(cap_o == ef, "R5 write frame bits", cap_o, ef);
      check(cap_oe == '1, "R5 write enable", cap_oe, '1);
      check(data_rdata == v.val, "R7 write keeps data", 64'(data_rdata), 64'(v.val));
    end else begin
      check(cap_o[63:18] == ef[63:18], "R6 read header bits", 64'(cap_o[63:18]), 64'(ef[63:18]));
      check(cap_oe == 64'hFFFF_FFFF_FFFC_0000, "R6 read release", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
      check(data_rdata == v.val, "R6 R7 read data", 64'(data_rdata), 64'(v.val));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not end actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [15:0] held_cmd;
    bit saw_mdc;
    int guard;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(cmd_rdata == 16'h0, "R10 cmd reset", 64'(cmd_rdata), 64'h0);
    check(data_rdata == 16'h0, "R10 data reset", 64'(data_rdata), 64'h0);
    check(mdc == 1'b0, "R10 mdc reset", 64'(mdc), 64'h0);
    check(mdio_oe == 1'b0, "R10 oe reset", 64'(mdio_oe), 64'h0);

    // R2 field update without start
    cmd_wr = 1'b1; cmd_wdata = {5'h13, 5'h07, 1'b0, 3'b011, 1'b1, 1'b0};
    @(negedge clk);
    cmd_wr = 1'b0;
    saw_mdc = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc || cmd_rdata[0]) saw_mdc = 1;
    end
    check(!saw_mdc, "R2 no start when bit0 clear", 64'(saw_mdc), 64'h0);
    check(cmd_rdata == 16'h99CE, "R1 R2 fields without start", 64'(cmd_rdata), 64'h99CE);

    foreach (VECS[i]) run_frame(VECS[i]);

    // R8 R9 writes during a running frame
    @(negedge clk);
    data_wr = 1'b1; data_wdata = 16'h1111;
    @(negedge clk);
    data_wr = 1'b0;
    cmd_wr = 1'b1; cmd_wdata = {5'h02, 5'h03, 1'b0, 3'b010, 1'b1, 1'b1};
    held_cmd = {5'h02, 5'h03, 1'b0, 3'b010, 1'b1, 1'b0};
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (50) @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = {5'h1C, 5'h1C, 1'b0, 3'b000, 1'b0, 1'b1};
    data_wr = 1'b1; data_wdata = 16'h2222;
    @(negedge clk);
    cmd_wr = 1'b0; data_wr = 1'b0;
    guard = 0;
    while (cmd_rdata[0] && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R7 busy clears", 64'(guard), 64'd1024);
    repeat (5) @(negedge clk);
    check(cmd_rdata == held_cmd, "R8 cmd ignored while busy", 64'(cmd_rdata), 64'(held_cmd));
    check(data_rdata == 16'h1111, "R9 data ignored while busy", 64'(data_rdata), 64'h1111);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 no second frame", 64'({mdc, mdio_oe}), 64'h0);

    summary();
  end
endmodule